// File: doc/BRIEF.md
# Codec Command Slot Controller

This block is the register-access path of an AC'97-style audio controller. Software uses it to read and write the registers of an external codec. It works on two 20-bit slot words. The slot 1 word carries a direction bit and a 7-bit codec register address. The slot 2 word carries 16 bits of register data.

Software first writes the data slot register and then the command slot register. The command write starts one transaction on a simple request/acknowledge codec register port. For a read, the block writes the result back into two receive registers, already placed in slot format. A flag register reports three things: whether each transmit slot is empty, whether a read is still outstanding, and whether unread receive data is waiting.

The local register bus has single-cycle strobes and a 3-bit register select. Read data is returned combinationally in the same cycle as the read strobe. Register selects are: 0 = slot 1 transmit, 1 = slot 2 transmit, 2 = slot 1 receive, 3 = slot 2 receive, 4 = flags.

Top module: `cmd_slot_ctrl`

## Requirements
- R1: After reset the flag register reads 0x07, both receive registers read zero, and `cdc_req_o` is low. Flag bits are: 0 = slot 1 transmit empty, 1 = slot 2 transmit empty, 2 = combined transmit empty, 3 = slot 1 receive busy, 4 = slot 2 receive busy, 5 = slot 1 receive valid, 6 = slot 2 receive valid.
- R2: Writing the slot 2 transmit register stores the word and clears flag bits 1 and 2.
- R3: An accepted write to the slot 1 transmit register does the following:
  - clears flag bits 0 and 2;
  - raises `cdc_req_o` on the following cycle;
  - drives `cdc_addr_o` from word bits 18:12;
  - sets `cdc_we_o` high when word bit 19 is 0 (write) and low when it is 1 (read).
- R4: During a transaction, `cdc_wdata_o` equals bits 19:4 of the slot 2 transmit word. `cdc_req_o` stays high until a cycle with `cdc_ack_i` high, and it is low on the cycle after that.
- R5: During a read transaction, flag bits 3 and 4 are set from the launch until the acknowledge. They are never set for a write transaction.
- R6: When a read is acknowledged, two registers are loaded. Slot 1 receive gets the command word with bit 19 cleared. Slot 2 receive gets `cdc_rdata_i` shifted left by 4. At the same time flag bits 3 and 4 clear and flag bits 5 and 6 set.
- R7: A slot 1 transmit write made while a transaction is outstanding is ignored. The stored command word, the codec address and direction, and the flags are unchanged, and no second transaction starts.
- R8: Reading the slot 1 receive register clears flag bit 5 only. Reading the slot 2 receive register clears flag bit 6 only.
- R9: A write transaction leaves both receive registers and flag bits 5 and 6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears receive valid flags) |
| sel_i | input | 3 | Register select |
| wdata_i | input | 20 | Register write data |
| rdata_o | output | 20 | Register read data, combinational on `sel_i` |
| cdc_req_o | output | 1 | Codec transaction request, held until acknowledged |
| cdc_we_o | output | 1 | 1 = codec register write, 0 = read |
| cdc_addr_o | output | 7 | Codec register address |
| cdc_wdata_o | output | 16 | Codec register write data |
| cdc_ack_i | input | 1 | Codec acknowledge, one cycle |
| cdc_rdata_i | input | 16 | Codec read result, valid with acknowledge |

## Verification
Some rules are checked by assertions on every cycle:
- the request is held until acknowledged and dropped right after;
- the command fields stay stable while a request is outstanding;
- the receive-busy flags agree with an outstanding read;
- an acknowledged read always leaves both valid flags set.

The directed scenarios are needed for everything else: the reset flag value, the bit placement of the returned data in the receive registers, the per-register clearing of the valid flags on read, and the fact that an ignored command write leaves the stored word intact and starts no extra transaction.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;
  typedef enum logic [2:0] {
    SEL_S1TX  = 3'd0,
    SEL_S2TX  = 3'd1,
    SEL_S1RX  = 3'd2,
    SEL_S2RX  = 3'd3,
    SEL_FLAGS = 3'd4
  } sel_e;

  localparam int NFLAGS  = 7;
  localparam int F_S1TXE = 0;
  localparam int F_S2TXE = 1;
  localparam int F_TXE   = 2;
  localparam int F_S1BSY = 3;
  localparam int F_S2BSY = 4;
  localparam int F_S1VLD = 5;
  localparam int F_S2VLD = 6;
endpackage

// File: rtl/cmd_slot_port.sv
module cmd_slot_port #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              dir_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (launch_i) begin
      req_o   <= 1'b1;
      we_o    <= ~dir_rd_i;
      addr_o  <= addr_i;
      wdata_o <= data_i;
    end else if (req_o && ack_i) begin
      req_o <= 1'b0;
    end
  end

  assign rd_done_o = req_o & ack_i & ~we_o;
endmodule

// File: rtl/cmd_slot_regs.sv
module cmd_slot_regs #(
  parameter int SLOT_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_s1_i,
  input  logic              wr_s2_i,
  input  logic [SLOT_W-1:0] wdata_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] cdc_rdata_i,
  output logic [SLOT_W-1:0] s1tx_o,
  output logic [SLOT_W-1:0] s2tx_o,
  output logic [SLOT_W-1:0] s1rx_o,
  output logic [SLOT_W-1:0] s2rx_o
);
  localparam int PAD_W = SLOT_W - DATA_W;
  localparam int DIR   = SLOT_W - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1tx_o <= '0;
      s2tx_o <= '0;
      s1rx_o <= '0;
      s2rx_o <= '0;
    end else begin
      if (wr_s1_i) s1tx_o <= wdata_i;
      if (wr_s2_i) s2tx_o <= wdata_i;
      if (rd_done_i) begin
        s1rx_o      <= s1tx_o;
        s1rx_o[DIR] <= 1'b0;
        s2rx_o      <= {cdc_rdata_i, {PAD_W{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/cmd_slot_flags.sv
module cmd_slot_flags
  import cmd_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_s1_i,
  input  logic              wr_s2_i,
  input  logic              launch_rd_i,
  input  logic              rd_done_i,
  input  logic              rd_s1rx_i,
  input  logic              rd_s2rx_i,
  output logic [NFLAGS-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= NFLAGS'(7'b000_0111);
    end else begin
      if (wr_s1_i) flags_o[F_S1TXE] <= 1'b0;
      if (wr_s2_i) flags_o[F_S2TXE] <= 1'b0;
      if (wr_s1_i || wr_s2_i) flags_o[F_TXE] <= 1'b0;
      if (launch_rd_i) begin
        flags_o[F_S1BSY] <= 1'b1;
        flags_o[F_S2BSY] <= 1'b1;
      end else if (rd_done_i) begin
        flags_o[F_S1BSY] <= 1'b0;
        flags_o[F_S2BSY] <= 1'b0;
      end
      // completion wins over a same-cycle read clear
      if (rd_done_i) begin
        flags_o[F_S1VLD] <= 1'b1;
        flags_o[F_S2VLD] <= 1'b1;
      end else begin
        if (rd_s1rx_i) flags_o[F_S1VLD] <= 1'b0;
        if (rd_s2rx_i) flags_o[F_S2VLD] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_slot_ctrl.sv
module cmd_slot_ctrl
  import cmd_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        sel_i,
  input  logic [SLOT_W-1:0] wdata_i,
  output logic [SLOT_W-1:0] rdata_o,
  output logic              cdc_req_o,
  output logic              cdc_we_o,
  output logic [ADDR_W-1:0] cdc_addr_o,
  output logic [DATA_W-1:0] cdc_wdata_o,
  input  logic              cdc_ack_i,
  input  logic [DATA_W-1:0] cdc_rdata_i
);
  localparam int DIR      = SLOT_W - 1;
  localparam int ADDR_LSB = DIR - ADDR_W;
  localparam int DATA_LSB = SLOT_W - DATA_W;

  logic [SLOT_W-1:0] s1tx, s2tx, s1rx, s2rx;
  logic [NFLAGS-1:0] flags;
  logic wr_s1, wr_s2, launch, rd_done;

  assign wr_s2  = wr_en_i && (sel_i == SEL_S2TX);
  assign wr_s1  = wr_en_i && (sel_i == SEL_S1TX) && !cdc_req_o;
  assign launch = wr_s1;

  cmd_slot_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .dir_rd_i  (wdata_i[DIR]),
    .addr_i    (wdata_i[DIR-1:ADDR_LSB]),
    .data_i    (s2tx[SLOT_W-1:DATA_LSB]),
    .ack_i     (cdc_ack_i),
    .req_o     (cdc_req_o),
    .we_o      (cdc_we_o),
    .addr_o    (cdc_addr_o),
    .wdata_o   (cdc_wdata_o),
    .rd_done_o (rd_done)
  );

  cmd_slot_regs #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_s1_i     (wr_s1),
    .wr_s2_i     (wr_s2),
    .wdata_i     (wdata_i),
    .rd_done_i   (rd_done),
    .cdc_rdata_i (cdc_rdata_i),
    .s1tx_o      (s1tx),
    .s2tx_o      (s2tx),
    .s1rx_o      (s1rx),
    .s2rx_o      (s2rx)
  );

  cmd_slot_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_s1_i     (wr_s1),
    .wr_s2_i     (wr_s2),
    .launch_rd_i (launch && wdata_i[DIR]),
    .rd_done_i   (rd_done),
    .rd_s1rx_i   (rd_en_i && (sel_i == SEL_S1RX)),
    .rd_s2rx_i   (rd_en_i && (sel_i == SEL_S2RX)),
    .flags_o     (flags)
  );

  always_comb begin
    case (sel_i)
      SEL_S1TX:  rdata_o = s1tx;
      SEL_S2TX:  rdata_o = s2tx;
      SEL_S1RX:  rdata_o = s1rx;
      SEL_S2RX:  rdata_o = s2rx;
      SEL_FLAGS: rdata_o = SLOT_W'(flags);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmd_slot_chk.sv
module cmd_slot_chk
  import cmd_slot_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req,
  input logic              ack,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NFLAGS-1:0] flags
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && !ack |=> req); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && ack |=> !req); // R4
  AST_CMD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && !ack |=> $stable(addr) && $stable(we) && $stable(wdata)); // R7
  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags[F_S2BSY:F_S1BSY] == {2{req && !we}}); // R5
  AST_VALID_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && ack && !we |=> flags[F_S2VLD:F_S1VLD] == 2'b11); // R6
endmodule

bind cmd_slot_ctrl cmd_slot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req   (cdc_req_o),
  .ack   (cdc_ack_i),
  .we    (cdc_we_o),
  .addr  (cdc_addr_o),
  .wdata (cdc_wdata_o),
  .flags (flags)
);

// File: tb/sim_cmd_slot_ctrl.sv
`timescale 1ns/1ps
module sim_cmd_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  sel = '0;
  logic [19:0] wdata = '0;
  logic [19:0] rdata;
  logic        req, we, ack = 1'b0;
  logic [6:0]  addr;
  logic [15:0] cwdata, crdata = '0;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cmd_slot_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata),
    .cdc_req_o(req), .cdc_we_o(we), .cdc_addr_o(addr),
    .cdc_wdata_o(cwdata), .cdc_ack_i(ack), .cdc_rdata_i(crdata)
  );

  task automatic chk(string tag, logic [19:0] got, logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%05h expected 0x%05h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] s, logic [19:0] d);
    @(negedge clk); wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] s, output logic [19:0] d);
    @(negedge clk); rd_en = 1'b1; sel = s;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic codec_ack(logic [15:0] d);
    @(negedge clk); ack = 1'b1; crdata = d;
    @(negedge clk); ack = 1'b0; crdata = '0;
  endtask

  task automatic t_reset();
    logic [19:0] v;
    bus_rd(3'd4, v); chk("R1 flags", v, 20'h07);
    bus_rd(3'd2, v); chk("R1 s1rx", v, 20'h0);
    bus_rd(3'd3, v); chk("R1 s2rx", v, 20'h0);
    chk("R1 req", 20'(req), 20'h0);
  endtask

  task automatic t_write_txn();
    logic [19:0] v;
    bus_wr(3'd1, 20'hABCD0);
    bus_rd(3'd4, v); chk("R2 flags", v, 20'h01);
    bus_wr(3'd0, 20'h15000);
    chk("R3 req", 20'(req), 20'h1);
    chk("R3 we", 20'(we), 20'h1);
    chk("R3 addr", 20'(addr), 20'h15);
    chk("R4 wdata", 20'(cwdata), 20'hABCD);
    bus_rd(3'd4, v); chk("R3 flags/R5 no busy on write", v, 20'h00);
    repeat (3) @(negedge clk);
    chk("R4 req held", 20'(req), 20'h1);
    codec_ack(16'h5555);
    chk("R4 req dropped", 20'(req), 20'h0);
    bus_rd(3'd4, v); chk("R9 flags", v, 20'h00);
    bus_rd(3'd2, v); chk("R9 s1rx", v, 20'h0);
    bus_rd(3'd3, v); chk("R9 s2rx", v, 20'h0);
  endtask

  task automatic t_read_txn();
    logic [19:0] v;
    bus_wr(3'd0, 20'hAA000);
    chk("R3 rd req", 20'(req), 20'h1);
    chk("R3 rd we", 20'(we), 20'h0);
    chk("R3 rd addr", 20'(addr), 20'h2A);
    bus_rd(3'd4, v); chk("R5 busy", v, 20'h18);
    bus_wr(3'd0, 20'h81000);
    chk("R7 addr kept", 20'(addr), 20'h2A);
    bus_rd(3'd0, v); chk("R7 s1tx kept", v, 20'hAA000);
    bus_rd(3'd4, v); chk("R7 flags kept", v, 20'h18);
    codec_ack(16'h1234);
    chk("R4 req dropped rd", 20'(req), 20'h0);
    bus_rd(3'd4, v); chk("R6 flags", v, 20'h60);
    bus_rd(3'd2, v); chk("R6 s1rx", v, 20'h2A000);
    bus_rd(3'd4, v); chk("R8 s1 clear", v, 20'h40);
    bus_rd(3'd3, v); chk("R6 s2rx", v, 20'h12340);
    bus_rd(3'd4, v); chk("R8 s2 clear", v, 20'h00);
    repeat (3) @(negedge clk);
    chk("R7 no second txn", 20'(req), 20'h0);
  endtask

  task automatic t_read_edge();
    logic [19:0] v;
    bus_wr(3'd0, 20'hFFFFF);
    chk("R3 addr max", 20'(addr), 20'h7F);
    codec_ack(16'hFFFF);
    bus_rd(3'd3, v); chk("R6 s2rx full", v, 20'hFFFF0);
    bus_rd(3'd4, v); chk("R8 only s2 cleared", v, 20'h20);
    bus_rd(3'd2, v); chk("R6 s1rx dir cleared", v, 20'h7FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_txn();
    t_read_txn();
    t_read_edge();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule